// File: doc/BRIEF.md
# Packet to Bus Transaction Converter

This block turns framed request packets into accesses on a 32-bit memory-mapped bus, then frames the outcome as a response packet. Requests arrive as a byte stream with start-of-packet and end-of-packet flags. Each request begins with an 8-byte header that carries an opcode, a byte count and a bus address. The block checks the request, performs one or more bus words of reads or writes, and streams the response out in the same byte form. A write is answered with a 4-byte status header. A read is answered with the data alone and no header.

The block handles one request at a time. Input is refused from the final byte of a request until the last response byte has left. Input and output are valid/ready streams. A byte moves when valid and ready are both high at a rising clock edge. The source must hold data and flags steady while valid is high and ready is low, and the block does the same on its output. The bus side is a request/acknowledge pair: the request stays high with address, direction and write data unchanged until the cycle that ack is high, so the bus may insert any number of wait states. Write payload is staged in a buffer of `WR_WORDS` words, so a bad request never reaches the bus.

Top module: `pkt_xact_bridge`

## Requirements
- R1: Header layout, one byte per beat, the first beat flagged start: byte 0 opcode, byte 1 ignored, bytes 2-3 the byte count (high byte first), bytes 4-7 the address (high byte first). A single write (opcode 0x00, count 4) carrying 4 payload bytes makes one bus write at that address. The payload is taken least significant byte first.
- R2: An incrementing write (opcode 0x04) with count 4·N, where 1 ≤ N ≤ WR_WORDS, and exactly 4·N payload bytes makes N bus writes. The address rises by 4 after each write.
- R3: A write response is 4 bytes: the opcode OR 0x80, then 0x00, then the count high byte, then the count low byte. Start is flagged on the first byte and end on the last.
- R4: A single read (opcode 0x10, count 4) with no payload makes one bus read. Its response is the 4 data bytes, least significant first, start on the first and end on the last.
- R5: An incrementing read (opcode 0x14) with count 4·N, where 1 ≤ N ≤ RD_WORDS, makes N bus reads at rising addresses 4 apart. It returns 4·N bytes, word by word, with start on the very first byte and end on the very last.
- R6: A request is dropped, with no bus access and no response, in any of these cases: it ends before 8 header bytes; a read carries payload; a write payload length differs from the count; a single opcode has a count other than 4; an incrementing count is zero, not a multiple of 4, or above the word limit. A packet that both starts and ends on one beat is also dropped.
- R7: Opcode 0x7F or any opcode outside the four above makes no bus access and is answered with 0xFF, 0x00, 0x00, 0x00. The length of the packet, once its header is complete, does not matter.
- R8: A start flag seen in the middle of a packet discards the partial request and begins a new header with that byte.
- R9: Bytes outside a packet are accepted and discarded. in_ready is low while a bus access or a response is pending. After reset in_ready is high with no bus request and no output valid.
- R10: bus_req, once raised, stays high with bus_addr, bus_we and bus_wdata stable until a cycle with bus_ack high.
- R11: While out_valid is high and out_ready is low, out_valid, out_data, out_sop and out_eop do not change on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request byte valid |
| in_ready | output | 1 | Block can take a request byte |
| in_data | input | 8 | Request byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Sink can take a response byte |
| out_data | output | 8 | Response byte |
| out_sop | output | 1 | First byte of the response |
| out_eop | output | 1 | Last byte of the response |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus access completes this cycle |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |

## Verification
The parser's restart on a start flag and its end-of-packet decision can both fall on the same beat. The bench sends a byte with both flags in the middle of a header, expects neither a bus access nor a response, and then checks that the next well-formed request is served normally. A second overlap is a bus acknowledge arriving while response bytes from the previous word are still held back by the sink. The bench varies the bus wait states and out_ready on different periods, so read-data arrival and output stalls line up in many ways. Every bus access and every response byte is compared in order against a scoreboard.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam logic [7:0] OP_WR     = 8'h00;
  localparam logic [7:0] OP_WR_INC = 8'h04;
  localparam logic [7:0] OP_RD     = 8'h10;
  localparam logic [7:0] OP_RD_INC = 8'h14;
  localparam logic [7:0] RSP_FLAG  = 8'h80;
  localparam logic [7:0] RSP_NONE  = 8'hFF;

  typedef enum logic [1:0] {K_WRITE, K_READ, K_NONE} req_kind_t;
  typedef enum logic [1:0] {ST_RX, ST_WR, ST_RD, ST_FLUSH} seq_state_t;
endpackage

// File: rtl/pxb_req_parser.sv
module pxb_req_parser
  import pxb_pkg::*;
#(
  parameter int WR_WORDS = 1,
  parameter int RD_WORDS = 256,
  localparam int WIW = (WR_WORDS > 1) ? $clog2(WR_WORDS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [7:0]     in_data,
  input  logic           in_sop,
  input  logic           in_eop,
  input  logic [WIW-1:0] wr_idx,
  output logic           done,
  output req_kind_t      kind,
  output logic [7:0]     opcode,
  output logic [15:0]    byte_cnt,
  output logic [31:0]    base_addr,
  output logic [13:0]    nwords,
  output logic [31:0]    wr_word
);
  localparam int CAPB = WR_WORDS * 4;

  logic        in_pkt;
  logic [3:0]  hidx;
  logic [16:0] pay_cnt;
  logic [7:0]  op_q;
  logic [15:0] cnt_q;
  logic [31:0] addr_q;
  logic        done_q;
  req_kind_t   kind_c;
  logic        single, cnt_ok, hdr_end_ok, pay_end_ok, store;
  logic [16:0] limit;
  logic [WR_WORDS*32-1:0] wflat;

  always_comb begin
    case (op_q)
      OP_WR, OP_WR_INC: kind_c = K_WRITE;
      OP_RD, OP_RD_INC: kind_c = K_READ;
      default:          kind_c = K_NONE;
    endcase
    single     = !op_q[2];
    limit      = (kind_c == K_WRITE) ? 17'(CAPB) : 17'(RD_WORDS * 4);
    cnt_ok     = single ? (cnt_q == 16'd4)
                        : (cnt_q != 16'd0 && cnt_q[1:0] == 2'b00 && {1'b0, cnt_q} <= limit);
    hdr_end_ok = (kind_c == K_NONE) || (kind_c == K_READ && cnt_ok);
    pay_end_ok = (kind_c == K_NONE) ||
                 (kind_c == K_WRITE && cnt_ok && (pay_cnt + 17'd1) == {1'b0, cnt_q});
    store      = take && !in_sop && in_pkt && hidx == 4'd8 && pay_cnt < 17'(CAPB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt  <= 1'b0;
      hidx    <= 4'd0;
      pay_cnt <= '0;
      op_q    <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        if (in_sop) begin
          in_pkt  <= !in_eop;
          hidx    <= 4'd1;
          op_q    <= in_data;
          cnt_q   <= '0;
          pay_cnt <= '0;
        end else if (in_pkt) begin
          if (hidx != 4'd8) begin
            case (hidx)
              4'd2: cnt_q[15:8]   <= in_data;
              4'd3: cnt_q[7:0]    <= in_data;
              4'd4: addr_q[31:24] <= in_data;
              4'd5: addr_q[23:16] <= in_data;
              4'd6: addr_q[15:8]  <= in_data;
              4'd7: addr_q[7:0]   <= in_data;
              default: ;
            endcase
            hidx <= hidx + 4'd1;
            if (in_eop) begin
              in_pkt <= 1'b0;
              done_q <= (hidx == 4'd7) && hdr_end_ok;
            end
          end else begin
            if (!pay_cnt[16]) pay_cnt <= pay_cnt + 17'd1;
            if (in_eop) begin
              in_pkt <= 1'b0;
              done_q <= pay_end_ok;
            end
          end
        end
      end
    end
  end

  for (genvar w = 0; w < WR_WORDS; w++) begin : g_wbuf
    logic [31:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (store && pay_cnt[16:2] == 15'(w)) word_q[8*pay_cnt[1:0] +: 8] <= in_data;
    end
    assign wflat[32*w +: 32] = word_q;
  end

  always_comb begin
    wr_word = '0;
    for (int w = 0; w < WR_WORDS; w++)
      if (wr_idx == WIW'(w)) wr_word = wflat[32*w +: 32];
  end

  assign done      = done_q;
  assign kind      = kind_c;
  assign opcode    = op_q;
  assign byte_cnt  = cnt_q;
  assign base_addr = addr_q;
  assign nwords    = single ? 14'd1 : cnt_q[15:2];

  // R6: a request is only released by a final byte that ended a packet
  p_done_after_eop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(take && in_eop && !in_sop));
endmodule

// File: rtl/pxb_rsp_tx.sv
module pxb_rsp_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] load_word,
  input  logic        load_first,
  input  logic        load_last,
  output logic        busy,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_sop,
  output logic        out_eop
);
  logic [31:0] sh_q;
  logic [2:0]  left_q;
  logic        first_q, last_q;

  assign busy      = (left_q != 3'd0);
  assign out_valid = busy;
  assign out_data  = sh_q[7:0];
  assign out_sop   = first_q && left_q == 3'd4;
  assign out_eop   = last_q && left_q == 3'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      left_q  <= 3'd0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (busy) begin
      if (out_ready) begin
        sh_q   <= {8'h00, sh_q[31:8]};
        left_q <= left_q - 3'd1;
      end
    end else if (load) begin
      sh_q    <= load_word;
      left_q  <= 3'd4;
      first_q <= load_first;
      last_q  <= load_last;
    end
  end

  // R11: a stalled byte keeps its value and flags
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));
  // R9: the sequencer never hands over a word while bytes are still pending
  p_load_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/pkt_xact_bridge.sv
module pkt_xact_bridge
  import pxb_pkg::*;
#(
  parameter int WR_WORDS = 1,
  parameter int RD_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_sop,
  output logic        out_eop,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata
);
  localparam int WIW = (WR_WORDS > 1) ? $clog2(WR_WORDS) : 1;

  seq_state_t  state_q, state_d;
  logic [13:0] widx_q;
  logic [31:0] addr_q;
  logic        take, p_done, last_word, step;
  req_kind_t   p_kind;
  logic [7:0]  p_op;
  logic [15:0] p_cnt;
  logic [31:0] p_base, p_wr_word;
  logic [13:0] p_nwords;
  logic        ld, ld_first, ld_last, tx_busy;
  logic [31:0] ld_word;

  assign in_ready = (state_q == ST_RX) && !p_done;
  assign take     = in_valid && in_ready;

  pxb_req_parser #(.WR_WORDS(WR_WORDS), .RD_WORDS(RD_WORDS)) u_parse (
    .clk(clk), .rst_n(rst_n), .take(take), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .wr_idx(widx_q[WIW-1:0]), .done(p_done), .kind(p_kind),
    .opcode(p_op), .byte_cnt(p_cnt), .base_addr(p_base), .nwords(p_nwords),
    .wr_word(p_wr_word)
  );

  pxb_rsp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_word(ld_word), .load_first(ld_first),
    .load_last(ld_last), .busy(tx_busy), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  assign last_word = (widx_q == p_nwords - 14'd1);
  assign bus_addr  = addr_q;
  assign step      = bus_req && bus_ack && !last_word;

  always_comb begin
    state_d   = state_q;
    ld        = 1'b0;
    ld_word   = '0;
    ld_first  = 1'b1;
    ld_last   = 1'b1;
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    case (state_q)
      ST_RX: if (p_done) begin
        case (p_kind)
          K_WRITE: state_d = ST_WR;
          K_READ:  state_d = ST_RD;
          default: begin
            ld      = 1'b1;
            ld_word = {24'h0, RSP_NONE};
            state_d = ST_FLUSH;
          end
        endcase
      end
      ST_WR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = p_wr_word;
        if (bus_ack && last_word) begin
          ld      = 1'b1;
          ld_word = {p_cnt[7:0], p_cnt[15:8], 8'h00, p_op | RSP_FLAG};
          state_d = ST_FLUSH;
        end
      end
      ST_RD: begin
        bus_req = !tx_busy;
        if (bus_req && bus_ack) begin
          ld       = 1'b1;
          ld_word  = bus_rdata;
          ld_first = (widx_q == 14'd0);
          ld_last  = last_word;
          if (last_word) state_d = ST_FLUSH;
        end
      end
      default: if (!tx_busy) state_d = ST_RX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RX;
      widx_q  <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RX && p_done) begin
        widx_q <= '0;
        addr_q <= p_base;
      end else if (step) begin
        widx_q <= widx_q + 14'd1;
        addr_q <= addr_q + 32'd4;
      end
    end
  end

  // R10: an access waiting for ack keeps its request and its fields
  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  // R9: no new request byte is taken while work for the last one is pending
  p_rx_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || out_valid) |-> !in_ready);
endmodule

// File: tb/pkt_xact_bridge_bench.sv
`timescale 1ns/1ps
module pkt_xact_bridge_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_sop, in_eop;
  logic [7:0] in_data;
  logic out_valid, out_ready, out_sop, out_eop;
  logic [7:0] out_data;
  logic bus_req, bus_we, bus_ack;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  pkt_xact_bridge #(.WR_WORDS(2), .RD_WORDS(256)) u_pkt_xact_bridge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [64:0] bq[$];
  string       bt[$];
  logic [9:0]  oq[$];
  string       ot[$];

  function automatic logic [31:0] rd_model(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h0101};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // bus slave model with varying wait states; compares every access
  int bus_cyc = 0, wait_left = 0;
  bit seen = 0;
  initial begin
    bus_ack = 0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      bus_ack = 0;
      bus_cyc++;
      if (rst_n && bus_req) begin
        if (!seen) begin
          seen = 1;
          wait_left = bus_cyc % 3;
          if (bq.size() == 0)
            check(0, "R6", "unexpected bus access", {bus_we, bus_addr, bus_wdata}, '0);
          else begin
            logic [64:0] e;
            string t;
            e = bq.pop_front(); t = bt.pop_front();
            check({bus_we, bus_addr, bus_we ? bus_wdata : 32'h0} == e, t, "bus access",
                  {bus_we, bus_addr, bus_we ? bus_wdata : 32'h0}, e);
          end
        end
        if (wait_left == 0) begin
          bus_ack = 1;
          bus_rdata = rd_model(bus_addr);
          seen = 0;
        end else wait_left--;
      end
    end
  end

  // response monitor with back-pressure
  int ocyc = 0;
  bit held = 0;
  logic [9:0] hold_v;
  initial begin
    out_ready = 0;
    forever begin
      @(negedge clk);
      ocyc++;
      if (held)
        check(out_valid && {out_sop, out_eop, out_data} == hold_v, "R11", "stalled byte changed",
              {out_valid, out_sop, out_eop, out_data}, {1'b1, hold_v});
      out_ready = (ocyc % 5) != 2 && (ocyc % 7) != 3;
      if (rst_n && out_valid && out_ready) begin
        if (oq.size() == 0)
          check(0, "R6", "unexpected response byte", {out_sop, out_eop, out_data}, '0);
        else begin
          logic [9:0] e;
          string t;
          e = oq.pop_front(); t = ot.pop_front();
          check({out_sop, out_eop, out_data} == e, t, "response byte", {out_sop, out_eop, out_data}, e);
        end
      end
      held = rst_n && out_valid && !out_ready;
      hold_v = {out_sop, out_eop, out_data};
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R9", "watchdog expired", '0, 1);
    report();
  end

  task automatic put(input logic [7:0] d, input bit s, input bit e);
    in_valid = 1; in_data = d; in_sop = s; in_eop = e;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [15:0] cnt,
                          input logic [31:0] a, input bit last);
    put(op, 1, 0); put(8'h00, 0, 0); put(cnt[15:8], 0, 0); put(cnt[7:0], 0, 0);
    put(a[31:24], 0, 0); put(a[23:16], 0, 0); put(a[15:8], 0, 0); put(a[7:0], 0, last);
  endtask

  task automatic send_word(input logic [31:0] w, input bit last);
    put(w[7:0], 0, 0); put(w[15:8], 0, 0); put(w[23:16], 0, 0); put(w[31:24], 0, last);
  endtask

  task automatic exp_bus(input bit we, input logic [31:0] a, input logic [31:0] d, input string t);
    bq.push_back({we, a, d}); bt.push_back(t);
  endtask

  task automatic exp_byte(input logic [7:0] d, input bit s, input bit e, input string t);
    oq.push_back({s, e, d}); ot.push_back(t);
  endtask

  task automatic exp_wrsp(input logic [7:0] op, input logic [15:0] cnt, input string t);
    exp_byte(op | 8'h80, 1, 0, t); exp_byte(8'h00, 0, 0, t);
    exp_byte(cnt[15:8], 0, 0, t); exp_byte(cnt[7:0], 0, 1, t);
  endtask

  task automatic exp_rd(input logic [31:0] a, input int n, input string t);
    for (int k = 0; k < n; k++) begin
      logic [31:0] w;
      w = rd_model(a + 32'(4 * k));
      exp_bus(0, a + 32'(4 * k), 32'h0, t);
      for (int b = 0; b < 4; b++)
        exp_byte(w[8*b +: 8], k == 0 && b == 0, k == n - 1 && b == 3, t);
    end
  endtask

  task automatic drain(input string t);
    int guard = 0;
    while ((bq.size() != 0 || oq.size() != 0) && guard < 30000) begin
      @(negedge clk); guard++;
    end
    repeat (10) @(negedge clk);
    check(bq.size() == 0 && oq.size() == 0 && in_ready && !out_valid && !bus_req, t,
          "idle after request", {bq.size() == 0, oq.size() == 0, in_ready, out_valid, bus_req},
          {1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_data = 0; in_sop = 0; in_eop = 0;
    repeat (5) @(negedge clk);
    check(in_ready && !out_valid && !bus_req, "R9", "reset state",
          {in_ready, out_valid, bus_req}, 3'b100);
    rst_n = 1;
    @(negedge clk);

    // R1 and R3: single write
    exp_bus(1, 32'h1000_0010, 32'hDEAD_BEEF, "R1");
    exp_wrsp(8'h00, 16'd4, "R3");
    send_hdr(8'h00, 16'd4, 32'h1000_0010, 0); send_word(32'hDEAD_BEEF, 1);
    drain("R1");

    // R2: incrementing write of two words
    exp_bus(1, 32'h0000_0200, 32'h1122_3344, "R2");
    exp_bus(1, 32'h0000_0204, 32'h5566_7788, "R2");
    exp_wrsp(8'h04, 16'd8, "R3");
    send_hdr(8'h04, 16'd8, 32'h0000_0200, 0);
    send_word(32'h1122_3344, 0); send_word(32'h5566_7788, 1);
    drain("R2");

    // R4: single read; R9: input closed while answering
    exp_rd(32'h0000_0030, 1, "R4");
    send_hdr(8'h10, 16'd4, 32'h0000_0030, 1);
    while (!out_valid) @(negedge clk);
    check(!in_ready, "R9", "input open during response", in_ready, 0);
    drain("R4");

    // R5: incrementing read of three words and of the word limit
    exp_rd(32'h0000_0400, 3, "R5");
    send_hdr(8'h14, 16'd12, 32'h0000_0400, 1);
    drain("R5");
    exp_rd(32'h0001_0000, 256, "R5");
    send_hdr(8'h14, 16'd1024, 32'h0001_0000, 1);
    drain("R5");

    // R7: no-transaction and unknown opcodes
    exp_wrsp(8'h7F, 16'd0, "R7");
    send_hdr(8'h7F, 16'd0, 32'h0, 1);
    drain("R7");
    exp_wrsp(8'h7F, 16'd0, "R7");
    send_hdr(8'h33, 16'd4, 32'h0000_0044, 0); put(8'h99, 0, 1);
    drain("R7");

    // R6: malformed requests are dropped
    put(8'h10, 1, 0); put(8'h00, 0, 0); put(8'h00, 0, 0); put(8'h04, 0, 0); put(8'h00, 0, 1);
    drain("R6");
    send_hdr(8'h00, 16'd4, 32'h20, 0); put(8'h01, 0, 0); put(8'h02, 0, 0); put(8'h03, 0, 1);
    drain("R6");
    send_hdr(8'h14, 16'd6, 32'h40, 1);
    drain("R6");
    send_hdr(8'h00, 16'd8, 32'h60, 0); send_word(32'h1, 0); send_word(32'h2, 1);
    drain("R6");
    send_hdr(8'h14, 16'd1028, 32'h80, 1);
    drain("R6");
    send_hdr(8'h04, 16'd12, 32'hA0, 0);
    send_word(32'h1, 0); send_word(32'h2, 0); send_word(32'h3, 1);
    drain("R6");
    send_hdr(8'h10, 16'd4, 32'hC0, 0); put(8'h00, 0, 1);
    drain("R6");
    send_hdr(8'h14, 16'd0, 32'hE0, 1);
    drain("R6");

    // R6 and R8: start and end on one beat inside a header
    put(8'h00, 1, 0); put(8'h00, 0, 0); put(8'h12, 1, 1);
    drain("R6");
    exp_bus(1, 32'h0000_0300, 32'hCAFE_F00D, "R1");
    exp_wrsp(8'h00, 16'd4, "R3");
    send_hdr(8'h00, 16'd4, 32'h0000_0300, 0); send_word(32'hCAFE_F00D, 1);
    drain("R1");

    // R8: restart in the middle of a header
    exp_rd(32'h0000_0080, 1, "R8");
    put(8'h10, 1, 0); put(8'h00, 0, 0); put(8'h00, 0, 0);
    send_hdr(8'h10, 16'd4, 32'h0000_0080, 1);
    drain("R8");

    // R9: bytes outside a packet are discarded
    exp_rd(32'h0000_0100, 1, "R9");
    put(8'h55, 0, 0); put(8'h7B, 0, 1);
    send_hdr(8'h10, 16'd4, 32'h0000_0100, 1);
    drain("R9");

    report();
  end
endmodule